// File: doc/BRIEF.md
# Read-Modify-Write File Register Datapath

This block is the execute stage for byte and bit operations on a banked, 8-bit-wide file register space that sits beside a single working register. Each accepted operation walks through three phases. First it reads the addressed file register, then it computes a new value, and finally it stores that value. The new value comes from a byte ALU function, or from setting, clearing or toggling one bit picked by a 3-bit index. It goes either to the working register or back into the same file register.

The target register is always read, even by operations that only store into it. A read strobe marks that read, so the register file around the block can model read side effects, such as a flag that clears when it is read. Bit operations store the whole captured byte with one bit changed. On a port-like register whose read returns pin levels, this copies those levels into the output latch.

An access selector picks how the 8-bit address is formed:
- Access-bank mode: the address falls into a fixed window. The low half of the address range lands in bank 0 and the high half lands in the top bank.
- Banked mode: the bank-select value is placed above the address.

A zero flag follows the results of byte operations.

Top module: `rmw_datapath`

## Requirements
- R1: An operation is accepted when `start` is high and the block is idle. The read strobe is high in the next cycle. The compute phase follows. `done` is high in the third cycle after acceptance, and the file write (if any) happens in that same cycle. `busy` is high from acceptance through the `done` cycle.
- R2: Every operation asserts `rf_rd_en` for exactly one cycle, at the target address. This includes operations whose result does not depend on the old value (clear, move-from-working). Read and write strobes are never high together.
- R3: With `d`=1, the result is written to the target file register as a full byte and `wreg` is unchanged. With `d`=0, no file write occurs and `wreg` takes the result at the end of the `done` cycle. `wreg` changes at no other time.
- R4: With `a`=1, the 12-bit register address is `{bsr, f}`.
- R5: With `a`=0, the address is `{4'h0, f}` when `f` < 0x80 and `{4'hF, f}` otherwise.
- R6: Byte operation codes work on F (the file register value) and W (the working register), modulo 256:
  - 0 passes F;
  - 1 computes F+W;
  - 2 computes F−W;
  - 3 computes F&W;
  - 4 computes F|W;
  - 5 computes F^W;
  - 6 computes F+1;
  - 7 computes F−1;
  - 8 computes ~F;
  - 9 yields 0;
  - 10 yields W.
- R7: Bit operation codes 11 (set), 12 (clear) and 13 (toggle) change only bit `b` of the captured byte. All other bits are written back exactly as they were read. Codes 14 and 15 pass F through unchanged.
- R8: Byte codes 0–9 set `zflag` to 1 when the result is 0 and to 0 otherwise. Codes 10–15 leave `zflag` unchanged.
- R9: `start` pulses while `busy` is high are ignored. They produce no extra read, write, `done` or `wreg` change.
- R10: After reset, `wreg` is 0, `zflag` is 0, and `busy`, `done`, `rf_rd_en` and `rf_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 4 | Operation code |
| f | input | 8 | File register address field |
| d | input | 1 | Destination: 0 working register, 1 file register |
| a | input | 1 | Access select: 0 access bank, 1 banked |
| b | input | 3 | Bit index for bit operations |
| bsr | input | 4 | Bank-select register value |
| rf_addr | output | 12 | Register file address |
| rf_rd_en | output | 1 | Read strobe (read phase) |
| rf_rd_data | input | 8 | Read data, valid in the read phase |
| rf_wr_en | output | 1 | Write strobe (final phase) |
| rf_wr_data | output | 8 | Write data |
| wreg | output | 8 | Working register |
| zflag | output | 1 | Zero flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final phase of an operation |

## Verification
A scoreboard predicts the destination, address, data, working register and zero flag of every operation from an independent reference. Operand pairs are chosen so that each byte code gives a result no other code would give, for example carry and borrow wrap, and all-ones incremented to zero. Banked and access-bank addresses on both sides of the 0x80 split tell the three mapping paths apart.

A port register that reads back pin levels, unlike its latch, shows whether bit operations store the sampled byte. Bit operations issued right after a zero result, together with clear and move-from-working operations, show that the zero flag is held and that reads always happen. A start pulse raised mid-operation must leave every port unaffected.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [3:0] {
        OP_PASS  = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_AND   = 4'd3,
        OP_IOR   = 4'd4,
        OP_XOR   = 4'd5,
        OP_INC   = 4'd6,
        OP_DEC   = 4'd7,
        OP_COM   = 4'd8,
        OP_CLR   = 4'd9,
        OP_MOVW  = 4'd10,
        OP_BSET  = 4'd11,
        OP_BCLR  = 4'd12,
        OP_BTOG  = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } rmw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_MODIFY = 2'd2,
        ST_WRITE  = 2'd3
    } rmw_state_e;

endpackage

// File: rtl/rmw_addr_map.sv
module rmw_addr_map #(
    parameter int unsigned F_W    = 8,
    parameter int unsigned BANK_W = 4,
    parameter logic [F_W-1:0] ACCESS_SPLIT = 8'h80
) (
    input  logic [F_W-1:0]        f_i,
    input  logic                  banked_i,
    input  logic [BANK_W-1:0]     bsr_i,
    output logic [BANK_W+F_W-1:0] addr_o
);
    localparam logic [BANK_W-1:0] LOW_BANK  = '0;
    localparam logic [BANK_W-1:0] HIGH_BANK = '1;

    always_comb begin
        if (banked_i) begin
            addr_o = {bsr_i, f_i};
        end else if (f_i < ACCESS_SPLIT) begin
            addr_o = {LOW_BANK, f_i};
        end else begin
            addr_o = {HIGH_BANK, f_i};
        end
    end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned BIT_W = $clog2(DATA_W)
) (
    input  rmw_op_e           op_i,
    input  logic [DATA_W-1:0] fval_i,
    input  logic [DATA_W-1:0] wval_i,
    input  logic [BIT_W-1:0]  bidx_i,
    output logic [DATA_W-1:0] res_o,
    output logic              zupd_o
);
    logic [DATA_W-1:0] mask;

    always_comb begin
        mask   = '0;
        mask[bidx_i] = 1'b1;
        zupd_o = 1'b1;
        case (op_i)
            OP_PASS: res_o = fval_i;
            OP_ADD:  res_o = fval_i + wval_i;
            OP_SUB:  res_o = fval_i - wval_i;
            OP_AND:  res_o = fval_i & wval_i;
            OP_IOR:  res_o = fval_i | wval_i;
            OP_XOR:  res_o = fval_i ^ wval_i;
            OP_INC:  res_o = fval_i + 1'b1;
            OP_DEC:  res_o = fval_i - 1'b1;
            OP_COM:  res_o = ~fval_i;
            OP_CLR:  res_o = '0;
            OP_MOVW: begin res_o = wval_i;          zupd_o = 1'b0; end
            OP_BSET: begin res_o = fval_i | mask;   zupd_o = 1'b0; end
            OP_BCLR: begin res_o = fval_i & ~mask;  zupd_o = 1'b0; end
            OP_BTOG: begin res_o = fval_i ^ mask;   zupd_o = 1'b0; end
            default: begin res_o = fval_i;          zupd_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath
    import rmw_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned F_W    = 8,
    parameter int unsigned BANK_W = 4,
    localparam int unsigned BIT_W = $clog2(DATA_W),
    localparam int unsigned A_W   = BANK_W + F_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op,
    input  logic [F_W-1:0]    f,
    input  logic              d,
    input  logic              a,
    input  logic [BIT_W-1:0]  b,
    input  logic [BANK_W-1:0] bsr,
    output logic [A_W-1:0]    rf_addr,
    output logic              rf_rd_en,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic [DATA_W-1:0] wreg,
    output logic              zflag,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        rmw_state_e        st;
        rmw_op_e           op;
        logic              dst;
        logic [BIT_W-1:0]  bidx;
        logic [A_W-1:0]    addr;
        logic [DATA_W-1:0] fval;
        logic [DATA_W-1:0] res;
        logic              zupd;
        logic [DATA_W-1:0] wreg;
        logic              z;
    } regs_t;

    regs_t             r_q, r_d;
    logic [A_W-1:0]    map_addr;
    logic [DATA_W-1:0] alu_res;
    logic              alu_zupd;

    rmw_addr_map #(.F_W(F_W), .BANK_W(BANK_W)) u_map (
        .f_i(f), .banked_i(a), .bsr_i(bsr), .addr_o(map_addr)
    );

    rmw_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i(r_q.op), .fval_i(r_q.fval), .wval_i(r_q.wreg),
        .bidx_i(r_q.bidx), .res_o(alu_res), .zupd_o(alu_zupd)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_READ;
                    r_d.op   = rmw_op_e'(op);
                    r_d.dst  = d;
                    r_d.bidx = b;
                    r_d.addr = map_addr;
                end
            end
            ST_READ: begin
                r_d.fval = rf_rd_data;
                r_d.st   = ST_MODIFY;
            end
            ST_MODIFY: begin
                r_d.res  = alu_res;
                r_d.zupd = alu_zupd;
                r_d.st   = ST_WRITE;
            end
            default: begin
                if (!r_q.dst) r_d.wreg = r_q.res;
                if (r_q.zupd) r_d.z    = (r_q.res == '0);
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, op: OP_PASS, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rf_addr    = r_q.addr;
    assign rf_rd_en   = (r_q.st == ST_READ);
    assign rf_wr_en   = (r_q.st == ST_WRITE) && r_q.dst;
    assign rf_wr_data = r_q.res;
    assign wreg       = r_q.wreg;
    assign zflag      = r_q.z;
    assign busy       = (r_q.st != ST_IDLE);
    assign done       = (r_q.st == ST_WRITE);

    // Write phase always follows a read two cycles earlier
    assert_read_before_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> $past(rf_rd_en, 2));

    assert_no_rd_wr_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_rd_en && rf_wr_en));

    assert_wreg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(wreg));

    assert_bit_single_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en && (r_q.op inside {OP_BSET, OP_BCLR, OP_BTOG}))
            |-> ($countones(rf_wr_data ^ r_q.fval) <= 1));

    assert_zero_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !r_q.zupd) |=> $stable(zflag));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(rf_addr));
endmodule

// File: tb/tb_rmw_datapath.sv
module tb_rmw_datapath;
    import rmw_pkg::*;

    localparam logic [11:0] PORT_A = 12'hF81;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [7:0]  f = '0;
    logic        d = 1'b0, a = 1'b0;
    logic [2:0]  b = '0;
    logic [3:0]  bsr = '0;
    logic [11:0] rf_addr;
    logic        rf_rd_en, rf_wr_en, busy, done, zflag;
    logic [7:0]  rf_rd_data, rf_wr_data, wreg;

    always #2 clk = ~clk;

    rmw_datapath dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .f(f), .d(d), .a(a),
        .b(b), .bsr(bsr), .rf_addr(rf_addr), .rf_rd_en(rf_rd_en),
        .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_data(rf_wr_data),
        .wreg(wreg), .zflag(zflag), .busy(busy), .done(done)
    );

    // Bench register file: the port reads pins, writes go to its latch
    logic [7:0]  mem [0:4095];
    logic [7:0]  pins = 8'hA5;
    logic [7:0]  latch;
    logic        poke_en = 1'b0;
    logic [11:0] poke_a = '0;
    logic [7:0]  poke_v = '0;

    assign rf_rd_data = (rf_addr == PORT_A) ? pins : mem[rf_addr];

    always @(posedge clk) begin
        if (poke_en) begin
            if (poke_a == PORT_A) latch <= poke_v;
            else mem[poke_a] <= poke_v;
        end else if (rf_wr_en) begin
            if (rf_addr == PORT_A) latch <= rf_wr_data;
            else mem[rf_addr] <= rf_wr_data;
        end
    end

    // Reference model
    logic [7:0] mdl [0:4095];
    logic [7:0] m_latch = '0;
    logic [7:0] m_w = '0;
    logic       m_z = 1'b0;

    typedef struct {
        logic        is_wr;
        logic [11:0] addr;
        logic [7:0]  data;
        logic [7:0]  w;
        logic        z;
        int          st_cyc;
    } exp_t;
    exp_t sb[$];

    int checks = 0, fails = 0, cyc = 0, rdcnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic poke(input logic [11:0] ad, input logic [7:0] v);
        @(negedge clk);
        poke_en = 1'b1; poke_a = ad; poke_v = v;
        if (ad == PORT_A) m_latch = v; else mdl[ad] = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    function automatic logic [11:0] map(input logic [7:0] ff, input logic aa, input logic [3:0] bk);
        if (aa) return {bk, ff};
        return (ff < 8'h80) ? {4'h0, ff} : {4'hF, ff};
    endfunction

    // Driver: predicts, pushes, then issues; optional start pulse while busy
    task automatic run(input logic [3:0] o, input logic [7:0] ff, input logic dd,
                       input logic aa, input logic [2:0] bb, input logic [3:0] bk,
                       input logic poke_busy = 1'b0);
        logic [11:0] ad;
        logic [7:0] fv, res, mk;
        logic zu;
        exp_t e;
        ad = map(ff, aa, bk);
        fv = (ad == PORT_A) ? pins : mdl[ad];
        mk = 8'h01 << bb;
        zu = (o <= 4'd9);
        case (o)
            4'd0: res = fv;          4'd1: res = fv + m_w;
            4'd2: res = fv - m_w;    4'd3: res = fv & m_w;
            4'd4: res = fv | m_w;    4'd5: res = fv ^ m_w;
            4'd6: res = fv + 8'd1;   4'd7: res = fv - 8'd1;
            4'd8: res = ~fv;         4'd9: res = 8'h00;
            4'd10: res = m_w;        4'd11: res = fv | mk;
            4'd12: res = fv & ~mk;   4'd13: res = fv ^ mk;
            default: res = fv;
        endcase
        if (dd) begin
            if (ad == PORT_A) m_latch = res; else mdl[ad] = res;
        end else m_w = res;
        if (zu) m_z = (res == 8'h00);
        @(negedge clk);
        e = '{is_wr: dd, addr: ad, data: res, w: m_w, z: m_z, st_cyc: cyc};
        sb.push_back(e);
        start = 1'b1; op = o; f = ff; d = dd; a = aa; b = bb; bsr = bk;
        @(negedge clk);
        start = poke_busy;
        if (poke_busy) begin op = 4'd9; f = 8'h22; d = 1'b1; a = 1'b0; end
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rf_rd_en) rdcnt++;
            if (done) begin
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R9: actual unexpected done expected none");
                end else begin
                    e = sb.pop_front();
                    chk("R1 done timing", cyc - e.st_cyc, 3);
                    chk("R2 one read per op", rdcnt, 1);
                    chk("R3 write strobe", rf_wr_en, e.is_wr);
                    chk("R4/R5 address", rf_addr, e.addr);
                    if (e.is_wr) chk("R6/R7 write data", rf_wr_data, e.data);
                    rdcnt = 0;
                    @(negedge clk);
                    chk("R3/R6 wreg", wreg, e.w);
                    chk("R8 zflag", zflag, e.z);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin mem[i] = 8'h00; mdl[i] = 8'h00; end
        latch = 8'h00;
        #(4 * 60000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 wreg", wreg, 0);     chk("R10 zflag", zflag, 0);
        chk("R10 busy", busy, 0);     chk("R10 done", done, 0);
        chk("R10 rd", rf_rd_en, 0);   chk("R10 wr", rf_wr_en, 0);
        rst_n = 1'b1;
        poke(12'h010, 8'h3C);
        poke(12'h240, 8'h05);
        poke(12'hF90, 8'h11);
        poke(12'h0FF, 8'h77);
        run(4'd0, 8'h10, 0, 0, 0, 0);      // R6 pass, R5 low access
        run(4'd1, 8'h10, 1, 0, 0, 0);      // R6 add -> 78
        run(4'd2, 8'h40, 0, 1, 0, 4'h2);   // R4 banked, sub wraps -> C9
        run(4'd5, 8'h40, 1, 1, 0, 4'h2);   // R6 xor
        run(4'd3, 8'h10, 0, 0, 0, 0);      // R6 and
        run(4'd4, 8'h90, 1, 0, 0, 0);      // R5 high access, ior
        run(4'd8, 8'h90, 0, 0, 0, 0);      // R6 com
        run(4'd7, 8'hFF, 1, 1, 0, 4'h0);   // R4 bank 0, dec
        poke(12'h033, 8'hFF);
        run(4'd6, 8'h33, 1, 0, 0, 0);      // R6 inc wraps to 0, R8 z=1
        run(4'd11, 8'h33, 1, 0, 3'd6, 0);  // R7 set, R8 z held
        run(4'd13, 8'h33, 1, 0, 3'd6, 0);  // R7 toggle back
        run(4'd9, 8'h10, 1, 0, 0, 0);      // R2 clear still reads, z=1
        run(4'd10, 8'h41, 1, 1, 0, 4'h7);  // R2 move-from-W reads, R8 hold
        run(4'd12, 8'h81, 1, 0, 3'd0, 0);  // R7 clear on port
        chk("R7 port latch takes pin levels", latch, 8'hA4);
        run(4'd15, 8'h10, 0, 0, 0, 0);     // R7 reserved pass, R8 hold
        run(4'd0, 8'h90, 0, 0, 0, 0, 1'b1);// R9 start while busy
        chk("R9 ignored target untouched", mem[12'h022], 8'h00);
        chk("R9 no pending results", sb.size(), 0);
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule